// File: doc/BRIEF.md
# TRS Word Framing Aligner

This block sits right behind a deserializer. The deserializer delivers one 10-bit word per clock but does not know where the true word boundary lies. The block slides a window across the incoming bit stream and looks for the timing-reference preamble at all ten bit offsets. It then re-cuts the stream so that the output words start on the boundary that the preamble marks. A preamble counts as valid only when its fourth word carries consistent protection bits.

The block has three realignment policies, chosen by a mode register and an enable input:

- **Lock once:** keep the first boundary found.
- **Follow every preamble:** move to the boundary of each preamble.
- **Follow only when pending:** move only while an off-boundary preamble is outstanding.

When a preamble is seen off the current boundary and the block does not move, a sticky new-sync-position flag is raised. A single-cycle strobe marks the cycle in which the fourth preamble word leaves the block on the current boundary.

Top module: `trs_word_aligner`

## Requirements
- R1: After reset, `alignedValid`, `trsSeen` and `nspFlag` are 0. Until the first valid preamble locks the block, `alignedValid` and `nspFlag` stay 0.
- R2: The serial stream is taken least-significant bit first: bit 0 of a raw word is the earliest bit. A preamble is the words 3FFh, 000h, 000h followed by a fourth word with these properties:
  - bit 9 is 1;
  - bit 8 is F, bit 7 is V and bit 6 is H;
  - bits 5, 4, 3 and 2 equal V^H, F^H, F^V and F^V^H;
  - bits 1:0 are ignored.

  The preamble is detected at any of the 10 bit offsets.
- R3: In every policy, the first valid preamble locks the boundary at its offset. The aligned word that starts at stream bit 10*i+offset appears at `alignedWord` five clock edges after the edge that samples raw word i. `alignedValid` rises in the same cycle that the 3FFh of the locking preamble appears.
- R4: `trsSeen` is a one-cycle pulse, given three cycles after the 3FFh, together with the fourth preamble word at the output. It fires only for a preamble that lies on the boundary in force after that preamble has been handled.
- R5: A candidate whose fourth word has bit 9 at 0 or wrong protection bits is ignored: it does not lock, strobe or move the boundary.
- R6: With mode 0 and `frameEn` 0, a preamble off the current boundary leaves the boundary unchanged. It sets `nspFlag` in the cycle its 3FFh would have appeared.
- R7: `nspFlag` stays set until the next valid preamble on the current boundary. It clears in the cycle that preamble's 3FFh appears.
- R8: With mode 0 and `frameEn` 1, every valid preamble moves the boundary to its own offset, and `nspFlag` stays 0.
- R9: With mode 1, `frameEn` is ignored. An off-boundary preamble while `nspFlag` is 0 sets the flag and does not move the boundary. An off-boundary preamble while the flag is set moves the boundary and clears the flag.
- R10: The mode register is 1 after reset. It loads `modeIn` on a clock edge where `modeWr` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawWord | input | 10 | Unaligned word from the deserializer, LSB earliest |
| modeWr | input | 1 | Loads the mode register from `modeIn` |
| modeIn | input | 1 | Policy select: 1 = follow only while NSP is pending |
| frameEn | input | 1 | In mode 0: 1 = follow every preamble, 0 = lock once |
| alignedWord | output | 10 | Word cut on the current boundary |
| alignedValid | output | 1 | Boundary has been locked |
| trsSeen | output | 1 | Fourth preamble word is on the output |
| nspFlag | output | 1 | Off-boundary preamble pending |

## Verification
Single preambles at offsets 0, 4 and 9 show that every bit offset is found and that the output is re-cut exactly there. An idle alternating-bit stream shows that nothing is found by accident. Candidates with a bad protection word and with bit 9 cleared must both be ignored, while a good preamble after them still locks. The same pattern is then run under the lock-once, follow-every and follow-when-pending policies: an on-boundary preamble, then an off-boundary one, then a third. The output boundary and the flag history tell the policies apart. A run that has no mode write shows that the register resets into the pending-only policy.

// File: rtl/trs_align_pkg.sv
package trs_align_pkg;
  localparam int WORD_W    = 10;
  localparam int TRS_WORDS = 4;
  localparam int OFF_W     = $clog2(WORD_W);
  localparam int WIN_WORDS = TRS_WORDS + 1;
  localparam int WIN_W     = WORD_W * WIN_WORDS;
  localparam int IDX_W     = $clog2(WIN_W);
  localparam int STRB_DLY  = TRS_WORDS - 1;

  typedef struct packed {
    logic             hit;
    logic [OFF_W-1:0] hitOff;
  } detect_t;

  typedef struct packed {
    logic             locked;
    logic [OFF_W-1:0] offSel;
  } alignCtl_t;
endpackage

// File: rtl/trs_align_datapath.sv
module trs_align_datapath
  import trs_align_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] rawWord,
  input  alignCtl_t         ctl,
  output detect_t           det,
  output logic [WORD_W-1:0] alignedWord,
  output logic              alignedValid,
  output logic              trsSeen
);
  logic [WIN_W-1:0]    win;
  logic [WORD_W-1:0]   hitVec;
  logic [STRB_DLY-1:0] strbPipe;
  logic [IDX_W-1:0]    selIdx;
  logic                hitOnBoundary;

  function automatic logic xyzOk(input logic [WORD_W-1:0] w);
    logic f, v, h;
    f = w[8];
    v = w[7];
    h = w[6];
    return w[9] && (w[5] == (v ^ h)) && (w[4] == (f ^ h)) &&
           (w[3] == (f ^ v)) && (w[2] == (f ^ v ^ h));
  endfunction

  // newest word enters at the top: older bits sit at lower positions
  always_ff @(posedge clk) begin
    if (!rstN) win <= '0;
    else       win <= {rawWord, win[WIN_W-1:WORD_W]};
  end

  for (genvar k = 0; k < WORD_W; k++) begin : g_off
    logic [WORD_W-1:0] w0, w1, w2, w3;
    assign w0 = win[k +: WORD_W];
    assign w1 = win[k + WORD_W +: WORD_W];
    assign w2 = win[k + 2*WORD_W +: WORD_W];
    assign w3 = win[k + 3*WORD_W +: WORD_W];
    assign hitVec[k] = (&w0) && (w1 == '0) && (w2 == '0) && xyzOk(w3);
  end

  always_comb begin
    det.hit    = |hitVec;
    det.hitOff = '0;
    for (int k = WORD_W - 1; k >= 0; k--) begin
      if (hitVec[k]) det.hitOff = OFF_W'(k);
    end
  end

  assign selIdx        = IDX_W'(ctl.offSel);
  assign hitOnBoundary = det.hit && (det.hitOff == ctl.offSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alignedWord  <= '0;
      alignedValid <= 1'b0;
      strbPipe     <= '0;
      trsSeen      <= 1'b0;
    end else begin
      alignedWord  <= win[selIdx +: WORD_W];
      alignedValid <= ctl.locked;
      strbPipe     <= {strbPipe[STRB_DLY-2:0], hitOnBoundary};
      trsSeen      <= strbPipe[STRB_DLY-1];
    end
  end
endmodule

// File: rtl/trs_align_ctrl.sv
module trs_align_ctrl
  import trs_align_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  detect_t   det,
  input  logic      modeWr,
  input  logic      modeIn,
  input  logic      frameEn,
  output alignCtl_t ctl,
  output logic      nspFlag
);
  logic             modeReg;
  logic             locked, lockedNext;
  logic [OFF_W-1:0] curOff, offNext;
  logic             nspNext;
  logic             mayMove;

  assign mayMove = modeReg ? nspFlag : frameEn;

  always_comb begin
    lockedNext = locked;
    offNext    = curOff;
    nspNext    = nspFlag;
    if (det.hit) begin
      if (!locked) begin
        lockedNext = 1'b1;
        offNext    = det.hitOff;
      end else if (det.hitOff == curOff) begin
        nspNext = 1'b0;
      end else if (mayMove) begin
        offNext = det.hitOff;
        nspNext = 1'b0;
      end else begin
        nspNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= 1'b1;
      locked  <= 1'b0;
      curOff  <= '0;
      nspFlag <= 1'b0;
    end else begin
      if (modeWr) modeReg <= modeIn;
      locked  <= lockedNext;
      curOff  <= offNext;
      nspFlag <= nspNext;
    end
  end

  assign ctl.locked = lockedNext;
  assign ctl.offSel = offNext;
endmodule

// File: rtl/trs_word_aligner.sv
module trs_word_aligner
  import trs_align_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] rawWord,
  input  logic              modeWr,
  input  logic              modeIn,
  input  logic              frameEn,
  output logic [WORD_W-1:0] alignedWord,
  output logic              alignedValid,
  output logic              trsSeen,
  output logic              nspFlag
);
  detect_t   det;
  alignCtl_t ctl;

  trs_align_datapath u_dp (
    .clk(clk), .rstN(rstN), .rawWord(rawWord), .ctl(ctl), .det(det),
    .alignedWord(alignedWord), .alignedValid(alignedValid), .trsSeen(trsSeen)
  );

  trs_align_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .det(det), .modeWr(modeWr), .modeIn(modeIn),
    .frameEn(frameEn), .ctl(ctl), .nspFlag(nspFlag)
  );
endmodule

// File: rtl/trs_align_checker.sv
module trs_align_checker
  import trs_align_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] rawWord,
  input logic              modeWr,
  input logic              modeIn,
  input logic              frameEn,
  input logic [WORD_W-1:0] alignedWord,
  input logic              alignedValid,
  input logic              trsSeen,
  input logic              nspFlag
);
  // R1
  nsp_needs_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !alignedValid |-> !nspFlag);

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(alignedValid));

  // R4
  strobe_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    trsSeen |-> alignedValid);

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    trsSeen |=> !trsSeen);

  // R2
  strobe_xyz_chk: assert property (@(posedge clk) disable iff (!rstN)
    trsSeen |-> (alignedWord[9] &&
                 alignedWord[5] == (alignedWord[7] ^ alignedWord[6]) &&
                 alignedWord[4] == (alignedWord[8] ^ alignedWord[6]) &&
                 alignedWord[3] == (alignedWord[8] ^ alignedWord[7]) &&
                 alignedWord[2] == (alignedWord[8] ^ alignedWord[7] ^ alignedWord[6])));

  // R4
  strobe_preamble_chk: assert property (@(posedge clk) disable iff (!rstN)
    trsSeen |-> ($past(alignedWord, 3) == '1 && $past(alignedWord, 2) == '0 &&
                 $past(alignedWord, 1) == '0));
endmodule

bind trs_word_aligner trs_align_checker chk (.*);

// File: tb/trs_word_aligner_test.sv
module trs_word_aligner_test;
  localparam int CLK_PERIOD  = 10;
  localparam int STREAM_BITS = 1200;
  localparam int MAX_EDGES   = 120;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] rawWord = '0;
  logic       modeWr = 1'b0;
  logic       modeIn = 1'b0;
  logic       frameEn = 1'b0;
  logic [9:0] alignedWord;
  logic       alignedValid, trsSeen, nspFlag;

  logic       sb   [0:STREAM_BITS-1];
  logic [9:0] recW [0:MAX_EDGES];
  logic       recV [0:MAX_EDGES];
  logic       recS [0:MAX_EDGES];
  logic       recN [0:MAX_EDGES];
  int checks = 0;
  int fails  = 0;

  trs_word_aligner uut (
    .clk(clk), .rstN(rstN), .rawWord(rawWord), .modeWr(modeWr), .modeIn(modeIn),
    .frameEn(frameEn), .alignedWord(alignedWord), .alignedValid(alignedValid),
    .trsSeen(trsSeen), .nspFlag(nspFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [9:0] streamWord(int pos);
    logic [9:0] v = '0;
    for (int b = 0; b < 10; b++)
      if (pos + b >= 0 && pos + b < STREAM_BITS) v[b] = sb[pos + b];
    return v;
  endfunction

  function automatic logic [9:0] expWord(int e, int off);
    return streamWord(10 * (e - 6) + off);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fillStream();
    for (int i = 0; i < STREAM_BITS; i++) sb[i] = i[0];
  endtask

  task automatic putWord(int pos, logic [9:0] v);
    for (int b = 0; b < 10; b++) sb[pos + b] = v[b];
  endtask

  task automatic putTrs(int pos, logic [9:0] xyz);
    putWord(pos, 10'h3FF);
    putWord(pos + 10, 10'h000);
    putWord(pos + 20, 10'h000);
    putWord(pos + 30, xyz);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    rawWord = '0;
    modeWr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic writeMode(logic m);
    modeIn = m;
    modeWr = 1'b1;
    @(posedge clk);
    #1 modeWr = 1'b0;
  endtask

  task automatic runStream(int n);
    for (int e = 1; e <= n; e++) begin
      rawWord = streamWord(10 * (e - 1));
      @(posedge clk);
      #1;
      recW[e] = alignedWord;
      recV[e] = alignedValid;
      recS[e] = trsSeen;
      recN[e] = nspFlag;
    end
  endtask

  task automatic checkSpan(int eFrom, int eTo, int off, string req);
    int badE = -1;
    for (int e = eFrom; e <= eTo; e++)
      if (badE < 0 && recW[e] !== expWord(e, off)) badE = e;
    if (badE < 0) check(1'b1, req, "span", 0, 0);
    else check(1'b0, req, $sformatf("word at edge %0d off %0d", badE, off),
               recW[badE], expWord(badE, off));
  endtask

  task automatic checkNspRange(int eFrom, int eTo, logic val, string req);
    int badE = -1;
    for (int e = eFrom; e <= eTo; e++)
      if (badE < 0 && recN[e] !== val) badE = e;
    check(badE < 0, req, $sformatf("nsp level from edge %0d", eFrom),
          (badE < 0) ? val : recN[badE], val);
  endtask

  task automatic checkTrsOut(int m, logic [9:0] xyz, string req);
    check(recW[m + 6] == 10'h3FF, req, "preamble at output", recW[m + 6], 10'h3FF);
    check(recS[m + 9] && recW[m + 9] == xyz && !recS[m + 8] && !recS[m + 10],
          req, "strobe with fourth word", {recS[m + 8], recS[m + 9], recS[m + 10]}, 3'b010);
  endtask

  // R1 reset values, R2 no false detection on idle stream
  task automatic testReset();
    int badV = 0;
    doReset();
    check(!alignedValid && !trsSeen && !nspFlag, "R1", "reset outputs",
          {alignedValid, trsSeen, nspFlag}, 0);
    fillStream();
    runStream(60);
    for (int e = 1; e <= 60; e++) if (recV[e] || recS[e] || recN[e]) badV++;
    check(badV == 0, "R1", "no lock on idle stream", badV, 0);
  endtask

  // R2 R3 R4 first lock at several offsets
  task automatic testFirstLock();
    int offs [3] = '{0, 4, 9};
    foreach (offs[i]) begin
      doReset();
      writeMode(1'b0);
      frameEn = 1'b0;
      fillStream();
      putTrs(200 + offs[i], 10'h274);
      runStream(80);
      check(!recV[25] && recV[26], "R3", $sformatf("valid rise off %0d", offs[i]),
            {recV[25], recV[26]}, 2'b01);
      checkTrsOut(20, 10'h274, "R4");
      checkSpan(26, 80, offs[i], "R3");
    end
  endtask

  // R5 bad fourth words ignored, good one then locks
  task automatic testBadXyz();
    int badV = 0;
    doReset();
    writeMode(1'b0);
    frameEn = 1'b1;
    fillStream();
    putTrs(203, 10'h278);
    putTrs(404, 10'h074);
    putTrs(605, 10'h200);
    runStream(90);
    for (int e = 1; e <= 65; e++) if (recV[e] || recS[e]) badV++;
    check(badV == 0, "R5", "bad candidates ignored", badV, 0);
    check(recV[66], "R5", "later good preamble locks", recV[66], 1);
    checkTrsOut(60, 10'h200, "R5");
    checkSpan(66, 90, 5, "R5");
  endtask

  // R6 R7 lock once, sticky flag
  task automatic testHold();
    doReset();
    writeMode(1'b0);
    frameEn = 1'b0;
    fillStream();
    putTrs(203, 10'h274);
    putTrs(506, 10'h200);
    putTrs(803, 10'h274);
    runStream(110);
    check(!recN[55] && recN[56], "R6", "nsp set by off-boundary preamble",
          {recN[55], recN[56]}, 2'b01);
    checkSpan(26, 85, 3, "R6");
    check(!recS[59], "R6", "no strobe off boundary", recS[59], 0);
    checkNspRange(56, 85, 1'b1, "R7");
    check(!recN[86], "R7", "nsp cleared by on-boundary preamble", recN[86], 0);
    checkTrsOut(80, 10'h274, "R7");
    checkSpan(86, 110, 3, "R6");
  endtask

  // R8 follow every preamble
  task automatic testFollow();
    doReset();
    writeMode(1'b0);
    frameEn = 1'b1;
    fillStream();
    putTrs(203, 10'h274);
    putTrs(506, 10'h200);
    runStream(90);
    checkSpan(26, 55, 3, "R8");
    checkTrsOut(50, 10'h200, "R8");
    checkSpan(56, 90, 6, "R8");
    checkNspRange(1, 90, 1'b0, "R8");
  endtask

  // R9 move only while flag pending
  task automatic testNspGate();
    doReset();
    writeMode(1'b1);
    frameEn = 1'b0;
    fillStream();
    putTrs(203, 10'h274);
    putTrs(506, 10'h200);
    putTrs(806, 10'h274);
    runStream(110);
    check(!recN[55] && recN[56], "R9", "first off-boundary sets nsp",
          {recN[55], recN[56]}, 2'b01);
    checkSpan(26, 85, 3, "R9");
    check(!recN[86], "R9", "second off-boundary clears nsp", recN[86], 0);
    checkTrsOut(80, 10'h274, "R9");
    checkSpan(86, 110, 6, "R9");
  endtask

  // R10 default mode is the pending-only policy, frameEn ignored there
  task automatic testDefaultMode();
    doReset();
    frameEn = 1'b1;
    fillStream();
    putTrs(203, 10'h274);
    putTrs(506, 10'h200);
    runStream(90);
    check(recN[56], "R10", "default mode flags instead of moving", recN[56], 1);
    checkSpan(26, 90, 3, "R10");
    check(!recS[59], "R10", "no strobe without move", recS[59], 0);
  endtask

  initial begin
    testReset();
    testFirstLock();
    testBadXyz();
    testHold();
    testFollow();
    testNspGate();
    testDefaultMode();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule